// File: doc/BRIEF.md
# Line Buffer Command Decoder and Mode Sequencer

This block sits behind the host write port of a serial line buffer. Each command word carries a four-bit opcode in its top bits. The block decodes that opcode, loads the configuration registers that the write port and the serial send engine read, and steps a mode machine through idle configuration, line loading, line transmission and a line-sent state. The command set that is legal depends on the current mode. A stop command always brings the block back to the idle configuration mode. It keeps the long-lived setup and drops all state that belongs to the current line.

The block drives an active-low interrupt when the send engine reports that a line has gone out. It can also restart transmission of the stored line without any new writes, and it can mark a line as filled entirely with the fixed level. All outputs are registered. A command sampled at a rising clock edge is visible on the outputs right after that edge.

Top module: `cmd_mode_seq`

## Requirements
- R1: After reset, every configuration output and the fill word count are zero. The block is in idle configuration mode, so in_write, in_send and line_sent are all 0. busy_n and intr_n are 1, and start_pulse and repeat_pulse are 0.
- R2: An accepted setup word (opcode 4'b1000) loads these fields: clk_sel_cont from bit 11, div_sel from bits 10:8, toggle_ext from bit 4, bus32_ext from bit 3, dma_mode from bit 2, prefix_en from bit 1 and fill_level from bit 0.
- R3: An accepted format word (opcode 4'b0100) loads lsb_first from bit 0 and lifo_order from bit 1. Opcode 4'b0111 loads dma_words from bits 8:0. Opcode 4'b0110 loads prefix_bits from bits 11:0.
- R4: Opcodes 4'b1000, 4'b0111, 4'b0110 and 4'b0100 take effect only in idle configuration mode. In any other mode they change nothing.
- R5: A mode word (opcode 4'b0000) with bits 1:0 = 2'b01 enters load mode (in_write = 1) from the idle, load or line-sent mode. It copies bit 3 into dma_mask and clears fill_line.
- R6: A mode word with bits 1:0 = 2'b10 enters send mode (in_send = 1, busy_n = 0) only from load or line-sent mode. It copies bit 3 into dma_mask and raises start_pulse for exactly one cycle. The same word in idle mode is ignored, and so are the low-bit values 2'b00 and 2'b11.
- R7: While in send mode, every command except stop is ignored.
- R8: line_done in send mode moves the block to line-sent mode (line_sent = 1, busy_n = 1) and drives intr_n low. line_done in any other mode has no effect.
- R9: Any host access (cmd_valid or host_access) returns intr_n to 1 on the next edge. If line_done is accepted on the same edge, intr_n goes low instead.
- R10: A repeat command (opcode 4'b0010) is accepted only in line-sent mode. It re-enters send mode and raises repeat_pulse for one cycle. In any other mode it is ignored.
- R11: A fill command (opcode 4'b0011) in load or line-sent mode loads fill_words from bits 8:0 and sets fill_line. In any other mode it is ignored.
- R12: A stop command (opcode 4'b1111) in any mode returns the block to idle mode. It wins over a line_done on the same edge. It clears dma_mask, fill_words and fill_line, sets intr_n and busy_n to 1, and leaves the setup, format, DMA count and prefix length registers unchanged.
- R13: Opcodes outside the eight defined ones change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe from the write port |
| cmd_word | input | 16 | Command word, opcode in bits 15:12 |
| host_access | input | 1 | Host data write seen by the write port |
| line_done | input | 1 | Send engine has shifted out the last bit |
| clk_sel_cont | output | 1 | 1 = continuous clock, 0 = request clock |
| div_sel | output | 3 | Continuous clock divide code |
| toggle_ext | output | 1 | Toggle cascade flag |
| bus32_ext | output | 1 | 32-bit cascade flag |
| dma_mode | output | 1 | Data arrives through DMA cycles |
| prefix_en | output | 1 | Send a fixed-level prefix before the line |
| fill_level | output | 1 | Fixed-data level |
| lifo_order | output | 1 | 1 = last word first |
| lsb_first | output | 1 | 1 = LSB shifted first |
| dma_words | output | 9 | DMA words per line, minus one |
| prefix_bits | output | 12 | Prefix length, minus one |
| fill_words | output | 9 | Fill line word count, minus one |
| fill_line | output | 1 | Line is taken as all fixed level |
| dma_mask | output | 1 | Suppress DMA request for this line |
| in_write | output | 1 | Load mode |
| in_send | output | 1 | Send mode |
| line_sent | output | 1 | Line-sent mode |
| busy_n | output | 1 | Low while sending |
| start_pulse | output | 1 | One cycle on entering send mode by command |
| repeat_pulse | output | 1 | One cycle on entering send mode by repeat |
| intr_n | output | 1 | Active-low line-sent interrupt |

## Verification
A wrong mode state shows at the ports on the edge right after the command that exposes it. For example, a setup word that lands outside idle mode alters a configuration output at once. A missing transition leaves in_write, in_send or line_sent wrong in the next sampled cycle. A mode mix-up that corrupts the interrupt shows on the next line_done or host access, because intr_n then fails to fall or to clear. A stop that clears too much or too little shows as a changed configuration field, or a lingering dma_mask or fill_line, in the cycle after the stop.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

   typedef enum logic [3:0] {
      OPC_SETUP  = 4'b1000,
      OPC_DMACNT = 4'b0111,
      OPC_PRELEN = 4'b0110,
      OPC_FORMAT = 4'b0100,
      OPC_MODE   = 4'b0000,
      OPC_FILL   = 4'b0011,
      OPC_REPEAT = 4'b0010,
      OPC_STOP   = 4'b1111
   } opcode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_SEND = 2'd2,
      ST_SENT = 2'd3
   } seq_state_e;

   // Bit positions inside the setup word: the write port and send engine
   // rely on these exact positions.
   localparam int unsigned SB_CLKSEL = 11;
   localparam int unsigned SB_DIV_HI = 10;
   localparam int unsigned SB_DIV_LO = 8;
   localparam int unsigned SB_TOGGLE = 4;
   localparam int unsigned SB_BUS32  = 3;
   localparam int unsigned SB_DMA    = 2;
   localparam int unsigned SB_PREFIX = 1;
   localparam int unsigned SB_LEVEL  = 0;

   localparam int unsigned MB_MASK   = 3;
   localparam logic [1:0]  MODE_LOAD = 2'b01;
   localparam logic [1:0]  MODE_SEND = 2'b10;

   typedef struct packed {
      logic       clk_cont;
      logic [2:0] div;
      logic       toggle;
      logic       bus32;
      logic       dma;
      logic       prefix;
      logic       level;
   } setup_t;

   typedef struct packed {
      logic lifo;
      logic lsb;
   } format_t;

endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
   import cmdseq_pkg::*;
#(
   parameter int unsigned CMD_W = 16,
   parameter int unsigned OPC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd_word,
   input  seq_state_e       state,
   output logic             wr_setup,
   output logic             wr_dmacnt,
   output logic             wr_prelen,
   output logic             wr_format,
   output logic             go_load,
   output logic             go_send,
   output logic             wr_fill,
   output logic             go_repeat,
   output logic             do_stop
);

   localparam int unsigned OPC_LO = CMD_W - OPC_W;

   generate
      if (OPC_W != 4) begin : g_bad_opc
         $error("cmdseq_decode: opcode field must be four bits");
      end
      if (CMD_W < OPC_W + 12) begin : g_bad_cmd
         $error("cmdseq_decode: command word too narrow for its fields");
      end
   endgenerate

   logic [OPC_W-1:0] opc;
   logic [1:0]       mode_lo;
   logic             st_idle, st_load, st_send, st_sent;

   assign opc     = cmd_word[CMD_W-1:OPC_LO];
   assign mode_lo = cmd_word[1:0];
   assign st_idle = (state == ST_IDLE);
   assign st_load = (state == ST_LOAD);
   assign st_send = (state == ST_SEND);
   assign st_sent = (state == ST_SENT);

   always_comb begin
      wr_setup  = 1'b0;
      wr_dmacnt = 1'b0;
      wr_prelen = 1'b0;
      wr_format = 1'b0;
      go_load   = 1'b0;
      go_send   = 1'b0;
      wr_fill   = 1'b0;
      go_repeat = 1'b0;
      do_stop   = 1'b0;
      if (cmd_valid) begin
         case (opc)
            OPC_SETUP:  wr_setup  = st_idle;
            OPC_DMACNT: wr_dmacnt = st_idle;
            OPC_PRELEN: wr_prelen = st_idle;
            OPC_FORMAT: wr_format = st_idle;
            OPC_MODE: begin
               go_load = (mode_lo == MODE_LOAD) && !st_send;
               go_send = (mode_lo == MODE_SEND) && (st_load || st_sent);
            end
            OPC_FILL:   wr_fill   = st_load || st_sent;
            OPC_REPEAT: go_repeat = st_sent;
            OPC_STOP:   do_stop   = 1'b1;
            default: ;
         endcase
      end
   end

   // R7
   send_only_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_send |-> !(wr_setup || wr_dmacnt || wr_prelen || wr_format ||
                    go_load || go_send || wr_fill || go_repeat));

   // R13
   single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_setup, wr_dmacnt, wr_prelen, wr_format, go_load,
                go_send, wr_fill, go_repeat, do_stop}));

endmodule

// File: rtl/cmdseq_cfg.sv
module cmdseq_cfg
   import cmdseq_pkg::*;
#(
   parameter int unsigned CMD_W  = 16,
   parameter int unsigned DCNT_W = 9,
   parameter int unsigned PLEN_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              wr_setup,
   input  logic              wr_dmacnt,
   input  logic              wr_prelen,
   input  logic              wr_format,
   input  logic              is_idle,
   output setup_t            setup_q,
   output format_t           format_q,
   output logic [DCNT_W-1:0] dcnt_q,
   output logic [PLEN_W-1:0] plen_q
);

   generate
      if (DCNT_W > CMD_W - 4 || PLEN_W > CMD_W - 4) begin : g_bad_w
         $error("cmdseq_cfg: count fields overlap the opcode");
      end
   endgenerate

   setup_t  setup_d;
   format_t format_d;

   always_comb begin
      setup_d.clk_cont = cmd_word[SB_CLKSEL];
      setup_d.div      = cmd_word[SB_DIV_HI:SB_DIV_LO];
      setup_d.toggle   = cmd_word[SB_TOGGLE];
      setup_d.bus32    = cmd_word[SB_BUS32];
      setup_d.dma      = cmd_word[SB_DMA];
      setup_d.prefix   = cmd_word[SB_PREFIX];
      setup_d.level    = cmd_word[SB_LEVEL];
      format_d.lifo    = cmd_word[1];
      format_d.lsb     = cmd_word[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         setup_q  <= '0;
         format_q <= '0;
         dcnt_q   <= '0;
         plen_q   <= '0;
      end else begin
         if (wr_setup)  setup_q  <= setup_d;
         if (wr_format) format_q <= format_d;
         if (wr_dmacnt) dcnt_q   <= cmd_word[DCNT_W-1:0];
         if (wr_prelen) plen_q   <= cmd_word[PLEN_W-1:0];
      end
   end

   // R4
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_idle |=> $stable({setup_q, format_q, dcnt_q, plen_q}));

endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
   import cmdseq_pkg::*;
#(
   parameter int unsigned CMD_W  = 16,
   parameter int unsigned FILL_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              cmd_valid,
   input  logic              host_access,
   input  logic              line_done,
   input  logic              go_load,
   input  logic              go_send,
   input  logic              wr_fill,
   input  logic              go_repeat,
   input  logic              do_stop,
   output seq_state_e        state_q,
   output logic [FILL_W-1:0] fill_words_q,
   output logic              fill_line_q,
   output logic              mask_q,
   output logic              start_q,
   output logic              repeat_q,
   output logic              intr_n_q
);

   logic line_end;
   assign line_end = line_done && (state_q == ST_SEND);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         fill_words_q <= '0;
         fill_line_q  <= 1'b0;
         mask_q       <= 1'b0;
         start_q      <= 1'b0;
         repeat_q     <= 1'b0;
         intr_n_q     <= 1'b1;
      end else if (do_stop) begin
         state_q      <= ST_IDLE;
         fill_words_q <= '0;
         fill_line_q  <= 1'b0;
         mask_q       <= 1'b0;
         start_q      <= 1'b0;
         repeat_q     <= 1'b0;
         intr_n_q     <= 1'b1;
      end else begin
         start_q  <= go_send;
         repeat_q <= go_repeat;
         if (go_load) begin
            state_q     <= ST_LOAD;
            mask_q      <= cmd_word[MB_MASK];
            fill_line_q <= 1'b0;
         end else if (go_send) begin
            state_q <= ST_SEND;
            mask_q  <= cmd_word[MB_MASK];
         end else if (go_repeat) begin
            state_q <= ST_SEND;
         end else if (line_end) begin
            state_q <= ST_SENT;
         end
         if (wr_fill) begin
            fill_words_q <= cmd_word[FILL_W-1:0];
            fill_line_q  <= 1'b1;
         end
         if (line_end) intr_n_q <= 1'b0;
         else if (cmd_valid || host_access) intr_n_q <= 1'b1;
      end
   end

   // R8
   intr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(intr_n_q) |-> (state_q == ST_SENT));

   // R6
   send_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEND) && $past(state_q != ST_SEND) |-> (start_q || repeat_q));

   // R10
   repeat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      repeat_q |-> $past(state_q == ST_SENT));

endmodule

// File: rtl/cmd_mode_seq.sv
module cmd_mode_seq
   import cmdseq_pkg::*;
#(
   parameter int unsigned CMD_W  = 16,
   parameter int unsigned OPC_W  = 4,
   parameter int unsigned DCNT_W = 9,
   parameter int unsigned PLEN_W = 12,
   parameter int unsigned FILL_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              host_access,
   input  logic              line_done,
   output logic              clk_sel_cont,
   output logic [2:0]        div_sel,
   output logic              toggle_ext,
   output logic              bus32_ext,
   output logic              dma_mode,
   output logic              prefix_en,
   output logic              fill_level,
   output logic              lifo_order,
   output logic              lsb_first,
   output logic [DCNT_W-1:0] dma_words,
   output logic [PLEN_W-1:0] prefix_bits,
   output logic [FILL_W-1:0] fill_words,
   output logic              fill_line,
   output logic              dma_mask,
   output logic              in_write,
   output logic              in_send,
   output logic              line_sent,
   output logic              busy_n,
   output logic              start_pulse,
   output logic              repeat_pulse,
   output logic              intr_n
);

   localparam int unsigned OPC_LO = CMD_W - OPC_W;

   seq_state_e state;
   setup_t     setup_q;
   format_t    format_q;
   logic wr_setup, wr_dmacnt, wr_prelen, wr_format;
   logic go_load, go_send, wr_fill, go_repeat, do_stop;

   cmdseq_decode #(.CMD_W(CMD_W), .OPC_W(OPC_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_word  (cmd_word),
      .state     (state),
      .wr_setup  (wr_setup),
      .wr_dmacnt (wr_dmacnt),
      .wr_prelen (wr_prelen),
      .wr_format (wr_format),
      .go_load   (go_load),
      .go_send   (go_send),
      .wr_fill   (wr_fill),
      .go_repeat (go_repeat),
      .do_stop   (do_stop)
   );

   cmdseq_cfg #(.CMD_W(CMD_W), .DCNT_W(DCNT_W), .PLEN_W(PLEN_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_word  (cmd_word),
      .wr_setup  (wr_setup),
      .wr_dmacnt (wr_dmacnt),
      .wr_prelen (wr_prelen),
      .wr_format (wr_format),
      .is_idle   (state == ST_IDLE),
      .setup_q   (setup_q),
      .format_q  (format_q),
      .dcnt_q    (dma_words),
      .plen_q    (prefix_bits)
   );

   cmdseq_fsm #(.CMD_W(CMD_W), .FILL_W(FILL_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_word     (cmd_word),
      .cmd_valid    (cmd_valid),
      .host_access  (host_access),
      .line_done    (line_done),
      .go_load      (go_load),
      .go_send      (go_send),
      .wr_fill      (wr_fill),
      .go_repeat    (go_repeat),
      .do_stop      (do_stop),
      .state_q      (state),
      .fill_words_q (fill_words),
      .fill_line_q  (fill_line),
      .mask_q       (dma_mask),
      .start_q      (start_pulse),
      .repeat_q     (repeat_pulse),
      .intr_n_q     (intr_n)
   );

   assign clk_sel_cont = setup_q.clk_cont;
   assign div_sel      = setup_q.div;
   assign toggle_ext   = setup_q.toggle;
   assign bus32_ext    = setup_q.bus32;
   assign dma_mode     = setup_q.dma;
   assign prefix_en    = setup_q.prefix;
   assign fill_level   = setup_q.level;
   assign lifo_order   = format_q.lifo;
   assign lsb_first    = format_q.lsb;
   assign in_write     = (state == ST_LOAD);
   assign in_send      = (state == ST_SEND);
   assign line_sent    = (state == ST_SENT);
   assign busy_n       = (state != ST_SEND);

   // R12
   stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_word[CMD_W-1:OPC_LO] == 4'b1111)
      |=> !in_write && !in_send && !line_sent && intr_n && !dma_mask && !fill_line);

   // R1
   one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({in_write, in_send, line_sent}));

   // R6
   start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

endmodule

// File: tb/sim_cmd_mode_seq.sv
module sim_cmd_mode_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        host_access = 1'b0;
   logic        line_done = 1'b0;

   logic        clk_sel_cont, toggle_ext, bus32_ext, dma_mode, prefix_en, fill_level;
   logic [2:0]  div_sel;
   logic        lifo_order, lsb_first, fill_line, dma_mask;
   logic [8:0]  dma_words, fill_words;
   logic [11:0] prefix_bits;
   logic        in_write, in_send, line_sent, busy_n, start_pulse, repeat_pulse, intr_n;

   always #4 clk = ~clk;

   cmd_mode_seq u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .host_access(host_access), .line_done(line_done),
      .clk_sel_cont(clk_sel_cont), .div_sel(div_sel), .toggle_ext(toggle_ext),
      .bus32_ext(bus32_ext), .dma_mode(dma_mode), .prefix_en(prefix_en),
      .fill_level(fill_level), .lifo_order(lifo_order), .lsb_first(lsb_first),
      .dma_words(dma_words), .prefix_bits(prefix_bits), .fill_words(fill_words),
      .fill_line(fill_line), .dma_mask(dma_mask), .in_write(in_write),
      .in_send(in_send), .line_sent(line_sent), .busy_n(busy_n),
      .start_pulse(start_pulse), .repeat_pulse(repeat_pulse), .intr_n(intr_n)
   );

   typedef struct {
      logic [50:0] v;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail = 0;
   bit   all_done = 1'b0;

   // reference model, built from the requirements
   int          m_st;
   logic        m_cs, m_tg, m_e32, m_dm, m_pe, m_fp, m_lf, m_ls, m_fl, m_mask, m_sp, m_rp, m_intr;
   logic [2:0]  m_dv;
   logic [8:0]  m_dw, m_fw;
   logic [11:0] m_pl;

   function automatic logic [50:0] dut_pack();
      return {clk_sel_cont, div_sel, toggle_ext, bus32_ext, dma_mode, prefix_en, fill_level,
              lifo_order, lsb_first, dma_words, prefix_bits, fill_words, fill_line, dma_mask,
              in_write, in_send, line_sent, busy_n, start_pulse, repeat_pulse, intr_n};
   endfunction

   function automatic logic [50:0] model_pack();
      return {m_cs, m_dv, m_tg, m_e32, m_dm, m_pe, m_fp, m_lf, m_ls, m_dw, m_pl, m_fw,
              m_fl, m_mask, (m_st == 1), (m_st == 2), (m_st == 3), (m_st != 2),
              m_sp, m_rp, m_intr};
   endfunction

   task automatic model_reset();
      m_st = 0; m_cs = 0; m_dv = 0; m_tg = 0; m_e32 = 0; m_dm = 0; m_pe = 0; m_fp = 0;
      m_lf = 0; m_ls = 0; m_dw = 0; m_pl = 0; m_fw = 0; m_fl = 0; m_mask = 0;
      m_sp = 0; m_rp = 0; m_intr = 1;
   endtask

   task automatic model_step(input logic cv, input logic [15:0] w, input logic ha, input logic ld);
      int prev;
      prev = m_st;
      m_sp = 0;
      m_rp = 0;
      if (cv && w[15:12] == 4'b1111) begin
         m_st = 0; m_mask = 0; m_fw = 0; m_fl = 0; m_intr = 1;
      end else begin
         if (cv) begin
            case (w[15:12])
               4'b1000: if (prev == 0) begin
                  m_cs = w[11]; m_dv = w[10:8]; m_tg = w[4]; m_e32 = w[3];
                  m_dm = w[2]; m_pe = w[1]; m_fp = w[0];
               end
               4'b0111: if (prev == 0) m_dw = w[8:0];
               4'b0110: if (prev == 0) m_pl = w[11:0];
               4'b0100: if (prev == 0) begin m_lf = w[1]; m_ls = w[0]; end
               4'b0000: begin
                  if (w[1:0] == 2'b01 && prev != 2) begin
                     m_st = 1; m_mask = w[3]; m_fl = 0;
                  end else if (w[1:0] == 2'b10 && (prev == 1 || prev == 3)) begin
                     m_st = 2; m_mask = w[3]; m_sp = 1;
                  end
               end
               4'b0011: if (prev == 1 || prev == 3) begin m_fw = w[8:0]; m_fl = 1; end
               4'b0010: if (prev == 3) begin m_st = 2; m_rp = 1; end
               default: ;
            endcase
         end
         if (ld && prev == 2) begin
            m_st = 3; m_intr = 0;
         end else if (cv || ha) begin
            m_intr = 1;
         end
      end
   endtask

   // driver: one clock per step, expected state pushed after the edge
   task automatic step(input logic cv, input logic [15:0] w, input logic ha,
                       input logic ld, input string req);
      exp_t e;
      @(negedge clk);
      cmd_valid = cv; cmd_word = w; host_access = ha; line_done = ld;
      model_step(cv, w, ha, ld);
      @(posedge clk);
      #1;
      e.v = model_pack();
      e.req = req;
      exp_q.push_back(e);
      cmd_valid = 1'b0; host_access = 1'b0; line_done = 1'b0;
   endtask

   task automatic cmd(input logic [15:0] w, input string req);
      step(1'b1, w, 1'b0, 1'b0, req);
   endtask

   task automatic idle(input string req);
      step(1'b0, 16'h0000, 1'b0, 1'b0, req);
   endtask

   // monitor: compares the oldest expected item halfway through the cycle
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         logic [50:0] got;
         e = exp_q.pop_front();
         got = dut_pack();
         n_checks++;
         if (got !== e.v) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", e.req, got, e.v);
         end
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle("R1 reset state");
      cmd(16'h8D17, "R2 setup fields");
      cmd(16'h7123, "R3 dma count");
      cmd(16'h6ABC, "R3 prefix length");
      cmd(16'h4003, "R3 format bits");
      cmd(16'h5FFF, "R13 unknown opcode 0101");
      cmd(16'h9FFF, "R13 unknown opcode 1001");
      cmd(16'h0002, "R6 send from idle ignored");
      cmd(16'h0003, "R6 low bits 11 ignored");
      cmd(16'h0009, "R5 enter load with mask");
      cmd(16'h8000, "R4 setup ignored in load");
      cmd(16'h4000, "R4 format ignored in load");
      cmd(16'h6001, "R4 prefix ignored in load");
      cmd(16'h31FF, "R11 fill in load");
      step(1'b0, 16'h0, 1'b1, 1'b0, "R9 host access no change");
      cmd(16'h2000, "R10 repeat in load ignored");
      step(1'b0, 16'h0, 1'b0, 1'b1, "R8 line_done in load ignored");
      cmd(16'h0002, "R6 send with start pulse");
      idle("R6 start pulse one cycle");
      cmd(16'h0001, "R7 load ignored in send");
      cmd(16'h3004, "R7 fill ignored in send");
      cmd(16'h7001, "R7 dma count ignored in send");
      step(1'b0, 16'h0, 1'b0, 1'b1, "R8 line done sets intr");
      idle("R8 intr held");
      step(1'b0, 16'h0, 1'b1, 1'b0, "R9 host access clears intr");
      step(1'b0, 16'h0, 1'b0, 1'b1, "R8 line_done outside send ignored");
      cmd(16'h2000, "R10 repeat from sent");
      step(1'b0, 16'h0, 1'b1, 1'b1, "R9 line_done beats access");
      cmd(16'h3005, "R11 fill in sent clears intr");
      cmd(16'h0001, "R5 load from sent clears fill");
      cmd(16'h000A, "R6 send with mask bit");
      step(1'b1, 16'hF000, 1'b0, 1'b1, "R12 stop beats line_done");
      idle("R12 config kept");
      cmd(16'h4001, "R4 format accepted after stop");
      cmd(16'h0001, "R5 load from idle");
      cmd(16'h3010, "R11 fill again");
      cmd(16'hF123, "R12 stop in load");
      cmd(16'h2000, "R10 repeat in idle ignored");
      idle("R12 final idle");
      wait (exp_q.size() == 0);
      @(posedge clk);
      all_done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!all_done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule